// File: doc/BRIEF.md
# Noise Voice with Decay Envelope and Length Gate

This block is the noise voice of a small synthesized-sound engine. A 15-bit shift register with exclusive-or feedback is stepped by a period divider. The divider's reload value comes from a 16-entry period table, and a mode bit picks one of two feedback taps. The short tap gives a loop of 93 steps, which sounds metallic. The long tap gives hiss.

Bit 14 of the shift register decides whether the voice sounds. When it is 1, the output is either a fixed volume or the level of a decaying envelope. Both the envelope and the length counter are clocked by quarter-frame and half-frame strobes from an external frame sequencer. The length counter is loaded from a 32-entry table when the length register is written. When it reaches zero, the voice is silenced.

Three write ports feed the voice, each a one-cycle strobe with a data byte: one for volume/envelope, one for period/mode and one for length. A level-sensitive enable input sits next to them. The outputs are a 4-bit amplitude and a flag that is high while the length counter is nonzero.

Top module: `noise_voice`

## Requirements
- R1: While reset is asserted and right after it, `amp_o` is 0 and `len_active_o` is 0. The shift register holds 1, the period select is index 0, and every envelope, length and volume field is 0.
- R2: Each step shifts the 15-bit register right by one. The new bit 14 is bit 0 XOR a tap bit. The tap is bit 1 when bit 7 of the last period/mode write is 0, and bit 6 when that bit is 1.
- R3: Bits 3:0 of the period/mode write select the step interval P, in clocks, from the list 4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068 (index 0 to 15). The register steps once every P clocks. The first step after reset happens on the 4th rising edge.
- R4: If a period write names a period shorter than the clocks still remaining before the next step, the remaining count is cut to the new P−1. The next step then comes no later than P clocks after the write.
- R5: `amp_o` equals the selected volume when bit 14 of the shift register is 1 and the length counter is nonzero. Otherwise it is 0.
- R6: In the volume write, bit 4 = 1 selects bits 3:0 as a constant volume. Bit 4 = 0 selects the envelope level.
- R7: A length write sets a restart flag. On the next quarter tick the envelope level becomes 15, the divider becomes 0 and the flag clears.
- R8: On a quarter tick without restart, the divider counts up by one. When the result exceeds bits 3:0 of the volume write, the divider returns to 0 and the level is clocked, which lowers a nonzero level by one.
- R9: A clocked level of 0 reloads to 15 when the loop bit (bit 5 of the volume write) is 1, and stays 0 otherwise.
- R10: A length write with the enable high loads the counter from a 32-entry table indexed by bits 7:3: 10,254,20,2,40,4,80,6,160,8,60,10,14,12,26,14,12,16,24,18,48,20,96,22,192,24,72,26,16,28,32,30. A length write with the enable low has no effect on the counter.
- R11: While the enable is low, the length counter is forced to 0 on every clock.
- R12: A half tick lowers a nonzero length counter by one when the loop bit is 0. When the loop bit is 1, the counter is frozen.
- R13: Length priority, highest first: enable low clears, then a length write loads, then a half tick decrements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Voice enable level |
| vol_we | input | 1 | Volume/envelope write strobe |
| vol_wdata | input | 8 | Bit 5 loop, bit 4 constant, bits 3:0 volume / envelope period |
| per_we | input | 1 | Period/mode write strobe |
| per_wdata | input | 8 | Bit 7 short tap, bits 3:0 period index |
| len_we | input | 1 | Length write strobe |
| len_wdata | input | 8 | Bits 7:3 length table index |
| qtr_tick | input | 1 | Quarter-frame strobe |
| half_tick | input | 1 | Half-frame strobe |
| amp_o | output | 4 | Voice amplitude |
| len_active_o | output | 1 | Length counter nonzero |

## Verification
The hardest situation to reach is the clamp of the step countdown. It only shows when a long period is running and a much shorter one is written part-way through the countdown. Its effect is visible only through the timing of the next amplitude change. The stimulus runs the longest period for several thousand cycles, then writes the shortest one. A cycle-accurate scoreboard compares every amplitude edge that follows. Same-cycle collisions are driven on purpose, so that the length priority order is observed at the ports: a load together with a half tick, and a load while disabled.

// File: rtl/noise_pkg.sv
package noise_pkg;

    localparam int PER_W = 12;
    localparam int LEN_W = 8;

    function automatic logic [PER_W-1:0] period_lut(input logic [3:0] idx);
        logic [PER_W-1:0] p;
        case (idx)
            4'd0:  p = 12'd4;
            4'd1:  p = 12'd8;
            4'd2:  p = 12'd16;
            4'd3:  p = 12'd32;
            4'd4:  p = 12'd64;
            4'd5:  p = 12'd96;
            4'd6:  p = 12'd128;
            4'd7:  p = 12'd160;
            4'd8:  p = 12'd202;
            4'd9:  p = 12'd254;
            4'd10: p = 12'd380;
            4'd11: p = 12'd508;
            4'd12: p = 12'd762;
            4'd13: p = 12'd1016;
            4'd14: p = 12'd2034;
            default: p = 12'd4068;
        endcase
        return p;
    endfunction

    // Odd indices above 1 give idx-1; even indices come from two scaled rows.
    function automatic logic [LEN_W-1:0] length_lut(input logic [4:0] idx);
        logic [LEN_W-1:0] v;
        if (idx == 5'd1) begin
            v = 8'd254;
        end else if (idx[0]) begin
            v = {3'b000, idx} - 8'd1;
        end else begin
            case (idx[3:1])
                3'd0: v = idx[4] ? 8'd12 : 8'd10;
                3'd1: v = idx[4] ? 8'd24 : 8'd20;
                3'd2: v = idx[4] ? 8'd48 : 8'd40;
                3'd3: v = idx[4] ? 8'd96 : 8'd80;
                3'd4: v = idx[4] ? 8'd192 : 8'd160;
                3'd5: v = idx[4] ? 8'd72 : 8'd60;
                3'd6: v = idx[4] ? 8'd16 : 8'd14;
                default: v = idx[4] ? 8'd32 : 8'd26;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/noise_shifter.sv
module noise_shifter
    import noise_pkg::*;
#(
    parameter int LFSR_W = 15,
    parameter int TAP_LONG = 1,
    parameter int TAP_SHORT = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       per_we,
    input  logic [7:0] per_wdata,
    output logic       gate_o
);

    typedef struct packed {
        logic [LFSR_W-1:0] sr;
        logic [PER_W-1:0]  cnt;
        logic [3:0]        sel;
        logic              short_mode;
    } shift_st_t;

    localparam shift_st_t RESET_ST = '{
        sr: LFSR_W'(1),
        cnt: PER_W'(3),
        sel: 4'd0,
        short_mode: 1'b0
    };

    shift_st_t st_q, st_d;
    logic [PER_W-1:0] cur_per, new_per;
    logic             tap_bit;
    logic [2:0]       unused_per_bits;

    assign unused_per_bits = per_wdata[6:4];

    always_comb begin
        cur_per = period_lut(st_q.sel);
        new_per = period_lut(per_wdata[3:0]);
        tap_bit = st_q.short_mode ? st_q.sr[TAP_SHORT] : st_q.sr[TAP_LONG];
        st_d = st_q;
        if (st_q.cnt == '0) begin
            st_d.sr  = {st_q.sr[0] ^ tap_bit, st_q.sr[LFSR_W-1:1]};
            st_d.cnt = cur_per - PER_W'(1);
        end else begin
            st_d.cnt = st_q.cnt - PER_W'(1);
        end
        if (per_we) begin
            st_d.sel        = per_wdata[3:0];
            st_d.short_mode = per_wdata[7];
            if (st_d.cnt > new_per - PER_W'(1)) begin
                st_d.cnt = new_per - PER_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_q.sr[LFSR_W-1];

    p_never_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sr != '0);
    p_step_changes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |=> (st_q.sr != $past(st_q.sr)));
    p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |=> $stable(st_q.sr));
    p_count_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < cur_per);

endmodule

// File: rtl/noise_env.sv
module noise_env #(
    parameter int VOL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vol_we,
    input  logic [7:0]       vol_wdata,
    input  logic             len_we,
    input  logic             qtr_tick,
    output logic [VOL_W-1:0] level_o,
    output logic             loop_o
);

    localparam logic [VOL_W-1:0] TOP = '1;

    typedef struct packed {
        logic [VOL_W-1:0] vol;
        logic             fixed;
        logic             loop;
        logic [VOL_W-1:0] lvl;
        logic [VOL_W-1:0] div;
        logic             restart;
    } env_st_t;

    env_st_t      st_q, st_d;
    logic [VOL_W:0] div_inc;
    logic [1:0]   unused_vol_bits;

    assign unused_vol_bits = vol_wdata[7:6];

    always_comb begin
        st_d    = st_q;
        div_inc = {1'b0, st_q.div} + (VOL_W+1)'(1);
        if (qtr_tick) begin
            if (st_q.restart) begin
                st_d.lvl     = TOP;
                st_d.div     = '0;
                st_d.restart = 1'b0;
            end else if (div_inc > {1'b0, st_q.vol}) begin
                st_d.div = '0;
                if (st_q.lvl != '0) begin
                    st_d.lvl = st_q.lvl - VOL_W'(1);
                end else if (st_q.loop) begin
                    st_d.lvl = TOP;
                end
            end else begin
                st_d.div = div_inc[VOL_W-1:0];
            end
        end
        if (len_we) begin
            st_d.restart = 1'b1;
        end
        if (vol_we) begin
            st_d.vol   = vol_wdata[VOL_W-1:0];
            st_d.fixed = vol_wdata[4];
            st_d.loop  = vol_wdata[5];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.fixed ? st_q.vol : st_q.lvl;
    assign loop_o  = st_q.loop;

    p_restart_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (qtr_tick && st_q.restart) |=> (st_q.lvl == TOP && st_q.div == '0));
    p_level_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (qtr_tick && !st_q.restart) |=> (st_q.lvl == $past(st_q.lvl)
            || st_q.lvl == $past(st_q.lvl) - VOL_W'(1)
            || ($past(st_q.lvl) == '0 && st_q.lvl == TOP)));
    p_no_tick_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !qtr_tick |=> $stable(st_q.lvl));
    p_floor_noloop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (qtr_tick && !st_q.restart && !st_q.loop && st_q.lvl == '0) |=> (st_q.lvl == '0));

endmodule

// File: rtl/noise_len.sv
module noise_len
    import noise_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_en,
    input  logic       len_we,
    input  logic [4:0] len_idx,
    input  logic       half_tick,
    input  logic       freeze,
    output logic       active_o
);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } len_st_t;

    len_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!chan_en) begin
            st_d.cnt = '0;
        end else if (len_we) begin
            st_d.cnt = length_lut(len_idx);
        end else if (half_tick && !freeze && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (st_q.cnt != '0);

    p_disable_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (st_q.cnt == '0));
    p_load_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && len_we) |=> (st_q.cnt != '0));
    p_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !len_we && freeze) |=> $stable(st_q.cnt));
    p_step_down_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !len_we && half_tick && !freeze && st_q.cnt != '0)
            |=> (st_q.cnt == $past(st_q.cnt) - LEN_W'(1)));

endmodule

// File: rtl/noise_voice.sv
module noise_voice #(
    parameter int LFSR_W = 15,
    parameter int TAP_LONG = 1,
    parameter int TAP_SHORT = 6,
    parameter int VOL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             vol_we,
    input  logic [7:0]       vol_wdata,
    input  logic             per_we,
    input  logic [7:0]       per_wdata,
    input  logic             len_we,
    input  logic [7:0]       len_wdata,
    input  logic             qtr_tick,
    input  logic             half_tick,
    output logic [VOL_W-1:0] amp_o,
    output logic             len_active_o
);

    logic             gate;
    logic             loop;
    logic [VOL_W-1:0] level;
    logic [2:0]       unused_len_bits;

    assign unused_len_bits = len_wdata[2:0];

    noise_shifter #(
        .LFSR_W(LFSR_W),
        .TAP_LONG(TAP_LONG),
        .TAP_SHORT(TAP_SHORT)
    ) u_shift (
        .clk(clk),
        .rst_n(rst_n),
        .per_we(per_we),
        .per_wdata(per_wdata),
        .gate_o(gate)
    );

    noise_env #(
        .VOL_W(VOL_W)
    ) u_env (
        .clk(clk),
        .rst_n(rst_n),
        .vol_we(vol_we),
        .vol_wdata(vol_wdata),
        .len_we(len_we),
        .qtr_tick(qtr_tick),
        .level_o(level),
        .loop_o(loop)
    );

    noise_len u_len (
        .clk(clk),
        .rst_n(rst_n),
        .chan_en(chan_en),
        .len_we(len_we),
        .len_idx(len_wdata[7:3]),
        .half_tick(half_tick),
        .freeze(loop),
        .active_o(len_active_o)
    );

    assign amp_o = (gate && len_active_o) ? level : '0;

    p_silent_when_expired_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !len_active_o |-> (amp_o == '0));
    p_silent_when_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |-> (amp_o == '0));

endmodule

// File: tb/sim_noise_voice.sv
module sim_noise_voice;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_en = 1'b0;
    logic       vol_we = 1'b0;
    logic [7:0] vol_wdata = '0;
    logic       per_we = 1'b0;
    logic [7:0] per_wdata = '0;
    logic       len_we = 1'b0;
    logic [7:0] len_wdata = '0;
    logic       qtr_tick = 1'b0;
    logic       half_tick = 1'b0;
    logic [3:0] amp_o;
    logic       len_active_o;

    int n_tests = 0;
    int n_fail = 0;
    string cur_req = "R1";

    int    q_amp[$];
    int    q_act[$];
    string q_tag[$];

    // reference state
    logic [14:0] m_sr = 15'd1;
    int          m_cnt = 3;
    int          m_sel = 0;
    bit          m_short = 0;
    int          m_vol = 0;
    bit          m_fixed = 0;
    bit          m_loop = 0;
    int          m_lvl = 0;
    int          m_div = 0;
    bit          m_restart = 0;
    int          m_len = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    noise_voice u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
        .vol_we(vol_we), .vol_wdata(vol_wdata),
        .per_we(per_we), .per_wdata(per_wdata),
        .len_we(len_we), .len_wdata(len_wdata),
        .qtr_tick(qtr_tick), .half_tick(half_tick),
        .amp_o(amp_o), .len_active_o(len_active_o)
    );

    function automatic int per_of(input int i);
        int t[16] = '{4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068};
        return t[i];
    endfunction

    function automatic int len_of(input int i);
        int t[32] = '{10, 254, 20, 2, 40, 4, 80, 6, 160, 8, 60, 10, 14, 12, 26, 14,
                      12, 16, 24, 18, 48, 20, 96, 22, 192, 24, 72, 26, 16, 28, 32, 30};
        return t[i];
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: drive, let the edge pass, advance the model, push expectation
    task automatic cyc(input bit vw, input logic [7:0] vd, input bit pw, input logic [7:0] pd,
                       input bit lw, input logic [7:0] ld, input bit qt, input bit ht);
        int  ncnt, np, d;
        bit  fb;
        vol_we = vw; vol_wdata = vd; per_we = pw; per_wdata = pd;
        len_we = lw; len_wdata = ld; qtr_tick = qt; half_tick = ht;
        @(posedge clk);
        // R2/R3/R4 model
        if (m_cnt == 0) begin
            fb = m_sr[0] ^ (m_short ? m_sr[6] : m_sr[1]);
            m_sr = {fb, m_sr[14:1]};
            ncnt = per_of(m_sel) - 1;
        end else begin
            ncnt = m_cnt - 1;
        end
        if (pw) begin
            np = per_of(int'(pd[3:0]));
            if (ncnt > np - 1) ncnt = np - 1;
            m_sel = int'(pd[3:0]);
            m_short = pd[7];
        end
        m_cnt = ncnt;
        // R10..R13 model
        if (!chan_en) m_len = 0;
        else if (lw) m_len = len_of(int'(ld[7:3]));
        else if (ht && !m_loop && m_len != 0) m_len = m_len - 1;
        // R7..R9 model
        if (qt) begin
            if (m_restart) begin
                m_lvl = 15; m_div = 0; m_restart = 0;
            end else begin
                d = m_div + 1;
                if (d > m_vol) begin
                    m_div = 0;
                    if (m_lvl != 0) m_lvl = m_lvl - 1;
                    else if (m_loop) m_lvl = 15;
                end else begin
                    m_div = d;
                end
            end
        end
        if (lw) m_restart = 1;
        if (vw) begin
            m_vol = int'(vd[3:0]); m_fixed = vd[4]; m_loop = vd[5];
        end
        q_amp.push_back((m_sr[14] && m_len != 0) ? (m_fixed ? m_vol : m_lvl) : 0);
        q_act.push_back(m_len != 0 ? 1 : 0);
        q_tag.push_back(cur_req);
        @(negedge clk);
        vol_we = 0; per_we = 0; len_we = 0; qtr_tick = 0; half_tick = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 8'h00, 0, 8'h00, 0, 0);
    endtask

    task automatic wr_vol(input logic [7:0] v); cyc(1, v, 0, 8'h00, 0, 8'h00, 0, 0); endtask
    task automatic wr_per(input logic [7:0] v); cyc(0, 8'h00, 1, v, 0, 8'h00, 0, 0); endtask
    task automatic wr_len(input logic [7:0] v); cyc(0, 8'h00, 0, 8'h00, 1, v, 0, 0); endtask

    // monitor: compare scoreboard items away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (q_amp.size() > 0) begin
                int    ea, ec;
                string tg;
                ea = q_amp.pop_front();
                ec = q_act.pop_front();
                tg = q_tag.pop_front();
                check({tg, " amp"}, int'(amp_o), ea);
                check({tg, " len_active"}, int'(len_active_o), ec);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 amp in reset", int'(amp_o), 0);
        check("R1 active in reset", int'(len_active_o), 0);
        rst_n = 1'b1;
        idle(2);
        check("R1 active after reset", int'(len_active_o), 0);

        // R5 / R6: constant volume, normal tap, shortest period
        chan_en = 1'b1;
        cur_req = "R6";
        wr_vol(8'h19);
        wr_len(8'h08);
        check("R10 load while enabled", int'(len_active_o), 1);
        idle(200);
        cur_req = "R5";
        wr_vol(8'h1C);
        idle(150);

        cur_req = "R2";
        wr_per(8'h82);
        idle(700);
        wr_per(8'h01);
        idle(300);

        cur_req = "R3";
        wr_per(8'h04);
        idle(800);
        wr_per(8'h0F);
        idle(9000);

        cur_req = "R4";
        wr_per(8'h00);
        idle(80);
        wr_per(8'h8D);
        idle(500);
        wr_per(8'h83);
        idle(200);

        // envelope with restart and decay
        cur_req = "R7";
        wr_per(8'h00);
        wr_vol(8'h03);
        wr_len(8'h08);
        cyc(0, 8'h00, 0, 8'h00, 0, 8'h00, 1, 0);
        idle(4);
        cur_req = "R8";
        for (int k = 0; k < 75; k++) begin
            cyc(0, 8'h00, 0, 8'h00, 0, 8'h00, 1, 0);
            idle(4);
        end
        cur_req = "R9";
        wr_vol(8'h22);
        for (int k = 0; k < 70; k++) begin
            cyc(0, 8'h00, 0, 8'h00, 0, 8'h00, 1, 0);
            idle(3);
        end

        // length decrement and freeze
        cur_req = "R12";
        wr_vol(8'h15);
        wr_len(8'h00);
        for (int k = 0; k < 10; k++) begin
            cyc(0, 8'h00, 0, 8'h00, 0, 8'h00, 0, 1);
            idle(2);
        end
        check("R12 expired after 10 half ticks", int'(len_active_o), 0);
        check("R5 silent after expiry", int'(amp_o), 0);
        wr_vol(8'h35);
        wr_len(8'h18);
        for (int k = 0; k < 20; k++) begin
            cyc(0, 8'h00, 0, 8'h00, 0, 8'h00, 0, 1);
            idle(2);
        end
        check("R12 frozen with loop set", int'(len_active_o), 1);

        // disable and ignored load
        cur_req = "R11";
        chan_en = 1'b0;
        idle(1);
        check("R11 disable clears", int'(len_active_o), 0);
        cur_req = "R10";
        wr_len(8'h08);
        check("R10 load ignored while disabled", int'(len_active_o), 0);
        chan_en = 1'b1;
        idle(2);
        check("R10 still empty after enable", int'(len_active_o), 0);

        // priority
        cur_req = "R13";
        wr_vol(8'h15);
        cyc(0, 8'h00, 0, 8'h00, 1, 8'h18, 0, 1);
        check("R13 load beats half tick", int'(len_active_o), 1);
        cyc(0, 8'h00, 0, 8'h00, 0, 8'h00, 0, 1);
        check("R13 one left", int'(len_active_o), 1);
        cyc(0, 8'h00, 0, 8'h00, 0, 8'h00, 0, 1);
        check("R13 expired", int'(len_active_o), 0);
        chan_en = 1'b0;
        cyc(0, 8'h00, 0, 8'h00, 1, 8'h08, 0, 0);
        check("R13 disable beats load", int'(len_active_o), 0);
        chan_en = 1'b1;
        idle(3);

        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule